// File: doc/BRIEF.md
# Stacked Clear-on-Read DMA Interrupt Status

This block holds the interrupt status of a bus-mastering DMA controller in one 8-bit register. It turns one-cycle event pulses from the DMA engine and from the bus interface into sticky status bits. Each interrupting bit has a one-deep stack. An event that arrives while its bit is already set is kept there. The same holds for an event that arrives in the cycle of a read that clears the bit. After the read, the kept event comes back into the bit.

A read strobe returns the register value and clears every bit that was set at that moment. A per-bit enable mask, written through a small write port, decides which set bits drive the summary interrupt request. Bit 7 does not interrupt: it always shows the live FIFO-empty level. A read that comes too soon after the previous read of this register or of a sibling status register raises an error pulse.

Top module: `dma_irq_status`

## Requirements
- R1: A one-cycle pulse on `ev_illegal`, `ev_script`, `ev_step` or `ev_abort` sets bit 0, 2, 3 or 4 in that order. The bit stays set with no further pulse until a read clears it.
- R2: Bit 6 is set when `is_master` and `par_chk_en` are both high and either `ev_par_det` or `ev_tgt_perr` pulses.
- R3: While `par_chk_en` is low, no pulse on `ev_par_det` or `ev_tgt_perr` sets bit 6.
- R4: Bit 5 is set by a pulse on `ev_bad_addr` or `ev_tgt_abort`, but only while `is_master` is high.
- R5: Bit 7 of `rd_data` follows `fifo_empty` in the same cycle. It never asserts `irq`.
- R6: During a cycle with `rd_stb` high, `rd_data` shows the value before clearing. Every bit in 6..0 that was set is 0 from the next cycle on.
- R7: An event on an already set bit is stacked, one level deep. So is an event that arrives in the cycle of a read that clears its bit. The stacked event sets the bit again one cycle after the clearing read.
- R8: `irq` is the OR over bits 6..0 of status AND mask. The mask is loaded from `mask_wdata` when `mask_we` is high, and the new mask takes effect from the next cycle. A masked bit does not assert `irq`. So `irq` drops after a clearing read and comes back when a stacked event refills an enabled bit.
- R9: A synchronous reset clears all status bits, stacks and mask bits, so `rd_data` reads `{fifo_empty, 7'b0}`. With the FIFO empty this gives 0x80. Bit 1 always reads 0.
- R10: A read of this register (`rd_stb`) or of a sibling status register (`sib_rd_stb`) is premature if it comes fewer than 12 cycles after the previous such read. A premature read raises `rd_err` for one cycle, the cycle after it. A premature read of this register still clears its bits. Reads exactly 12 cycles apart raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe for this status register |
| sib_rd_stb | input | 1 | Read strobe of either sibling status register (spacing only) |
| ev_illegal | input | 1 | Illegal instruction event pulse (bit 0) |
| ev_script | input | 1 | Program interrupt event pulse (bit 2) |
| ev_step | input | 1 | Single-step event pulse (bit 3) |
| ev_abort | input | 1 | Abort event pulse (bit 4) |
| ev_par_det | input | 1 | Data parity error detected as master |
| ev_tgt_perr | input | 1 | Target signalled a data-phase parity error |
| ev_bad_addr | input | 1 | Cycle ended with a bad address |
| ev_tgt_abort | input | 1 | Cycle ended with a target abort |
| is_master | input | 1 | Controller currently owns the bus |
| par_chk_en | input | 1 | Master parity error enable |
| fifo_empty | input | 1 | Live DMA FIFO empty level |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | Mask write data, bit i enables status bit i |
| rd_data | output | 8 | Status register view |
| irq | output | 1 | Summary DMA interrupt request |
| rd_err | output | 1 | Premature read pulse |

## Verification
A bit cell that drops its stacked event shows up at the first read after it. The bit then stays 0 on the cycle after the read instead of coming back, and `irq` stays low. A cell that fails to clear shows up on `rd_data` one cycle after the read. A mask or gating fault is visible on `irq` or on bit 5/6 in the cycle right after the stimulus pulse. A spacing counter that is off by one shows up as a wrong `rd_err` at the read exactly 11 or 12 cycles after the previous read.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int STAT_W       = 8;
    localparam int BIT_ILLEGAL  = 0;
    localparam int BIT_RSVD     = 1;
    localparam int BIT_SCRIPT   = 2;
    localparam int BIT_STEP     = 3;
    localparam int BIT_ABORT    = 4;
    localparam int BIT_BUSFAULT = 5;
    localparam int BIT_MPAR     = 6;
    localparam int BIT_FIFOMT   = 7;

    // bits that are sticky, stacked and able to interrupt
    localparam logic [STAT_W-1:0] IRQ_BITS = 8'b0111_1101;

    // per-bit cell state: {visible bit, stacked event}
    typedef enum logic [1:0] {
        CELL_IDLE    = 2'b00,
        CELL_REFILL  = 2'b01,
        CELL_SET     = 2'b10,
        CELL_STACKED = 2'b11
    } cell_state_t;

    typedef struct packed {
        logic fifo_empty;
        logic mpar;
        logic bus_fault;
        logic abort;
        logic step;
        logic script;
        logic rsvd;
        logic illegal;
    } dstat_view_t;

    function automatic logic cell_visible(cell_state_t s);
        return (s == CELL_SET) || (s == CELL_STACKED);
    endfunction

endpackage

// File: rtl/dstat_event_map.sv
module dstat_event_map
    import dma_irq_pkg::*;
(
    input  logic              ev_illegal,
    input  logic              ev_script,
    input  logic              ev_step,
    input  logic              ev_abort,
    input  logic              ev_par_det,
    input  logic              ev_tgt_perr,
    input  logic              ev_bad_addr,
    input  logic              ev_tgt_abort,
    input  logic              is_master,
    input  logic              par_chk_en,
    output logic [STAT_W-1:0] ev_vec
);

    always_comb begin
        ev_vec               = '0;
        ev_vec[BIT_ILLEGAL]  = ev_illegal;
        ev_vec[BIT_SCRIPT]   = ev_script;
        ev_vec[BIT_STEP]     = ev_step;
        ev_vec[BIT_ABORT]    = ev_abort;
        ev_vec[BIT_BUSFAULT] = is_master & (ev_bad_addr | ev_tgt_abort);
        ev_vec[BIT_MPAR]     = is_master & par_chk_en & (ev_par_det | ev_tgt_perr);
    end

endmodule

// File: rtl/dstat_event_cell.sv
module dstat_event_cell
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic rd,
    output logic bit_o
);

    cell_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE:    state_d = ev ? CELL_SET : CELL_IDLE;
            CELL_SET:     if (rd) state_d = ev ? CELL_REFILL : CELL_IDLE;
                          else    state_d = ev ? CELL_STACKED : CELL_SET;
            CELL_STACKED: state_d = rd ? CELL_REFILL : CELL_STACKED;
            CELL_REFILL:  state_d = ev ? CELL_STACKED : CELL_SET;
            default:      state_d = CELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CELL_IDLE;
        else     state_q <= state_d;
    end

    assign bit_o = cell_visible(state_q);

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && bit_o) |=> !bit_o);

    assert_stack_return_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && bit_o && ev) |-> ##2 bit_o);

    assert_no_spont_set_R1: assert property (@(posedge clk) disable iff (rst)
        (!bit_o && state_q != CELL_REFILL && !ev) |=> !bit_o);

endmodule

// File: rtl/dstat_read_guard.sv
module dstat_read_guard #(
    parameter int MIN_GAP = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_any,
    output logic rd_err
);

    localparam int CNT_W = $clog2(MIN_GAP + 1);
    localparam logic [CNT_W-1:0] GAP_C = CNT_W'(MIN_GAP);

    logic [CNT_W-1:0] since_q;
    logic             busy;

    assign busy = since_q < GAP_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= GAP_C;
            rd_err  <= 1'b0;
        end else begin
            rd_err <= rd_any & busy;
            if (rd_any)           since_q <= CNT_W'(1);
            else if (busy)        since_q <= since_q + CNT_W'(1);
        end
    end

    assert_window_opens_R10: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> busy);

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int MIN_GAP = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              sib_rd_stb,
    input  logic              ev_illegal,
    input  logic              ev_script,
    input  logic              ev_step,
    input  logic              ev_abort,
    input  logic              ev_par_det,
    input  logic              ev_tgt_perr,
    input  logic              ev_bad_addr,
    input  logic              ev_tgt_abort,
    input  logic              is_master,
    input  logic              par_chk_en,
    input  logic              fifo_empty,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq,
    output logic              rd_err
);

    logic [STAT_W-1:0] ev_vec;
    logic [STAT_W-1:0] stat;
    logic [STAT_W-1:0] mask_q;
    dstat_view_t       view;

    dstat_event_map u_map (
        .ev_illegal   (ev_illegal),
        .ev_script    (ev_script),
        .ev_step      (ev_step),
        .ev_abort     (ev_abort),
        .ev_par_det   (ev_par_det),
        .ev_tgt_perr  (ev_tgt_perr),
        .ev_bad_addr  (ev_bad_addr),
        .ev_tgt_abort (ev_tgt_abort),
        .is_master    (is_master),
        .par_chk_en   (par_chk_en),
        .ev_vec       (ev_vec)
    );

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (IRQ_BITS[i]) begin : g_cell
            dstat_event_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .ev    (ev_vec[i]),
                .rd    (rd_stb),
                .bit_o (stat[i])
            );
        end else begin : g_tie
            assign stat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata & IRQ_BITS;
    end

    always_comb begin
        view            = dstat_view_t'(stat);
        view.fifo_empty = fifo_empty;
        view.rsvd       = 1'b0;
    end

    assign rd_data = view;
    assign irq     = |(stat & mask_q & IRQ_BITS);

    dstat_read_guard #(.MIN_GAP(MIN_GAP)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .rd_any (rd_stb | sib_rd_stb),
        .rd_err (rd_err)
    );

    assert_par_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (!par_chk_en && !stat[BIT_MPAR] && !$past(rd_stb)) |=> !stat[BIT_MPAR]);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    typedef struct packed {
        logic       rd;
        logic [5:0] ev;    // {mpar, bad_addr, abort, step, script, illegal}
        logic [7:0] exp_stat;
        logic       exp_irq;
    } vec_t;

    // R1 R4 R6 R7 R8: sticky set, stacking, clear-on-read, refill, irq
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'b001000, 8'h10, 1'b1},
        '{1'b0, 6'b001000, 8'h10, 1'b1},
        '{1'b0, 6'b000001, 8'h11, 1'b1},
        '{1'b1, 6'b000000, 8'h00, 1'b0},
        '{1'b0, 6'b000000, 8'h10, 1'b1},
        '{1'b0, 6'b000100, 8'h18, 1'b1},
        '{1'b0, 6'b000010, 8'h1C, 1'b1},
        '{1'b0, 6'b010000, 8'h3C, 1'b1},
        '{1'b0, 6'b100000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b0, 6'b000000, 8'h7C, 1'b1},
        '{1'b1, 6'b100000, 8'h00, 1'b0},
        '{1'b0, 6'b000000, 8'h40, 1'b1},
        '{1'b0, 6'b100000, 8'h40, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 0, sib_rd_stb = 0;
    logic       ev_illegal = 0, ev_script = 0, ev_step = 0, ev_abort = 0;
    logic       ev_par_det = 0, ev_tgt_perr = 0, ev_bad_addr = 0, ev_tgt_abort = 0;
    logic       is_master = 1, par_chk_en = 1, fifo_empty = 0;
    logic       mask_we = 0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       irq, rd_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .sib_rd_stb(sib_rd_stb),
        .ev_illegal(ev_illegal), .ev_script(ev_script), .ev_step(ev_step),
        .ev_abort(ev_abort), .ev_par_det(ev_par_det), .ev_tgt_perr(ev_tgt_perr),
        .ev_bad_addr(ev_bad_addr), .ev_tgt_abort(ev_tgt_abort),
        .is_master(is_master), .par_chk_en(par_chk_en), .fifo_empty(fifo_empty),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rd_data(rd_data), .irq(irq), .rd_err(rd_err)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ev();
        ev_illegal = 0; ev_script = 0; ev_step = 0; ev_abort = 0;
        ev_par_det = 0; ev_tgt_perr = 0; ev_bad_addr = 0; ev_tgt_abort = 0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic set_mask(logic [7:0] m);
        mask_we = 1; mask_wdata = m;
        tick();
        mask_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        idle(2);
        rst = 0;
        set_mask(8'h7D);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            rd_stb      = VECS[v].rd;
            ev_par_det  = VECS[v].ev[5];
            ev_bad_addr = VECS[v].ev[4];
            ev_abort    = VECS[v].ev[3];
            ev_step     = VECS[v].ev[2];
            ev_script   = VECS[v].ev[1];
            ev_illegal  = VECS[v].ev[0];
            tick();
            rd_stb = 0; clear_ev();
            chk($sformatf("R1 R6 R7 table vec %0d status", v), rd_data, VECS[v].exp_stat);
            chk($sformatf("R8 table vec %0d irq", v), {7'b0, irq}, {7'b0, VECS[v].exp_irq});
            chk($sformatf("R10 table vec %0d no error", v), {7'b0, rd_err}, 8'h00);
        end

        // R9: reset state with FIFO empty
        fifo_empty = 1; rst = 1;
        idle(2);
        rst = 0;
        chk("R9 reset value", rd_data, 8'h80);
        chk("R9 reset irq", {7'b0, irq}, 8'h00);
        chk("R9 reset rd_err", {7'b0, rd_err}, 8'h00);

        // R5: bit 7 live and non-interrupting
        set_mask(8'hFF);
        chk("R5 fifo empty no irq", {7'b0, irq}, 8'h00);
        fifo_empty = 0;
        #1;
        chk("R5 fifo level follows", rd_data, 8'h00);
        fifo_empty = 1;
        #1;
        chk("R5 fifo level returns", rd_data, 8'h80);
        fifo_empty = 0;

        // R3: parity gated off by enable
        par_chk_en = 0; ev_par_det = 1; ev_tgt_perr = 1;
        tick(); clear_ev();
        chk("R3 parity suppressed", rd_data, 8'h00);
        par_chk_en = 1;

        // R4: bus fault only as master
        is_master = 0; ev_bad_addr = 1; ev_tgt_abort = 1;
        tick(); clear_ev();
        chk("R4 no fault when not master", rd_data, 8'h00);
        is_master = 1; ev_tgt_abort = 1;
        tick(); clear_ev();
        chk("R4 target abort fault", rd_data, 8'h20);

        // R2: target parity error as master
        ev_tgt_perr = 1;
        tick(); clear_ev();
        chk("R2 target parity error", rd_data, 8'h60);

        // R8: mask gating
        set_mask(8'h00);
        chk("R8 all masked", {7'b0, irq}, 8'h00);
        set_mask(8'h20);
        chk("R8 bus fault enabled", {7'b0, irq}, 8'h01);
        set_mask(8'h1D);
        chk("R8 only quiet bits enabled", {7'b0, irq}, 8'h00);

        // R6: read returns pre-clear value, then clears
        rd_stb = 1;
        #1;
        chk("R6 read value", rd_data, 8'h60);
        tick(); rd_stb = 0;
        chk("R6 cleared after read", rd_data, 8'h00);

        // R10: premature own read
        idle(4);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R10 early read flagged", {7'b0, rd_err}, 8'h01);
        tick();
        chk("R10 flag is a pulse", {7'b0, rd_err}, 8'h00);
        idle(10);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R10 read at gap 12 clean", {7'b0, rd_err}, 8'h00);
        idle(3);
        sib_rd_stb = 1; tick(); sib_rd_stb = 0;
        chk("R10 sibling read early", {7'b0, rd_err}, 8'h01);

        // R7: event coincident with clearing read, with R8 irq return
        set_mask(8'h10);
        ev_abort = 1; tick(); clear_ev();
        chk("R7 abort set", rd_data, 8'h10);
        idle(12);
        rd_stb = 1; ev_abort = 1;
        tick(); rd_stb = 0; clear_ev();
        chk("R7 cleared in read cycle", rd_data, 8'h00);
        chk("R8 irq drops on read", {7'b0, irq}, 8'h00);
        tick();
        chk("R7 stacked event returns", rd_data, 8'h10);
        chk("R8 irq returns", {7'b0, irq}, 8'h01);
        chk("R10 spaced read clean", {7'b0, rd_err}, 8'h00);

        finish_run();
    end

endmodule